// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block turns the transmitter's NRZ bit stream into short infrared light pulses. A data bit of value 0 lights the emitter for a short burst placed inside its bit cell. A data bit of value 1 leaves the emitter dark. The burst width comes from one of two sources. In normal mode it is three ticks of the 16x bit-rate clock enable, which is 3/16 of a bit. In low-power mode it lasts until the third tick of a separate low-power reference enable, so the width does not depend on the bit rate.

The transmitter marks every bit cell with `cell_start`, which it raises together with the tick that opens the cell. The encoder only runs while both the SIR enable and the UART enable are set. While it runs, the plain serial output stays in the marking state. While it is off, the emitter stays dark and activity on the infrared receive pin is not passed on. A loopback control gives two test paths. With the SIR test control set, the emitter's light state is sent to the SIR receive path. With the test control clear, the plain serial output is sent to the serial receive path.

Top module: `sir_pulse_enc`

## Requirements
- R1: With the encoder active in normal mode, a 0 on `tx_nrz` at the tick of index 7 (the tick that carries `cell_start` is index 0) drives `ir_led_n` to 0 from the clock edge of that tick until the clock edge of the tick of index 10, which is three tick periods.
- R2: A 1 on `tx_nrz` at the tick of index 7 produces no light: `ir_led_n` stays 1 for the whole cell.
- R3: In low-power mode (`lp_sel`=1), the pulse starts at the same edge as in R1. It ends at the edge of the third `lp_tick` that comes after the start edge, whatever the `tick16` rate.
- R4: Once a pulse has started, it runs to its full width even if `tx_nrz` changes during the pulse.
- R5: While `sir_en`=0 or `uart_en`=0, `ir_led_n` is 1, `ir_sense` is 0 whatever `ir_rx_n` does, and `txd` follows `tx_nrz`.
- R6: While `sir_en`=1 and `uart_en`=1, `txd` is 1 and `rxd_path` is 1. Outside SIR test loopback, `ir_sense` is the inverse of `ir_rx_n`.
- R7: With the encoder active and both `loop_en` and `sir_test` set, `ir_sense` equals the emitter light state (the inverse of `ir_led_n`), and `ir_rx_n` is ignored.
- R8: With `loop_en`=1, `sir_test`=0 and the encoder inactive, `rxd_path` equals `txd`. Without loopback, `rxd_path` equals `rxd`.
- R9: During and just after reset, `ir_led_n` is 1 (no light).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uart_en | input | 1 | UART enable; the SIR enable has no effect while this is 0 |
| sir_en | input | 1 | Infrared encoder enable |
| lp_sel | input | 1 | 1 selects low-power pulse width |
| loop_en | input | 1 | Loopback enable |
| sir_test | input | 1 | With loopback, sends the emitter state to the SIR receive path |
| tick16 | input | 1 | 16x bit-rate clock enable |
| cell_start | input | 1 | Raised with the tick that opens a bit cell |
| lp_tick | input | 1 | Low-power reference clock enable |
| tx_nrz | input | 1 | NRZ transmit bit from the serializer |
| rxd | input | 1 | Plain serial receive pin |
| ir_rx_n | input | 1 | Infrared receive pin, 0 = light detected |
| txd | output | 1 | Plain serial transmit pin |
| rxd_path | output | 1 | Serial data toward the receiver |
| ir_led_n | output | 1 | Infrared emitter, 0 = light |
| ir_sense | output | 1 | Light indication toward the SIR decoder, 1 = light |

## Verification
A wrong cell-tick counter shows up as a pulse that starts too early or too late. This is seen within one bit cell as a wrong offset from `cell_start` to the first light cycle. A wrong width counter or a wrongly latched width source changes the number of light cycles in that same cell. The low-power width is checked against an arithmetic count of reference ticks at several phases and at two bit rates. Errors in routing and gating are combinational and appear in the cycle the controls change.

// File: rtl/sir_pkg.sv
package sir_pkg;
   typedef enum logic {
      WIDTH_TICK = 1'b0,
      WIDTH_LP   = 1'b1
   } width_src_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sir_cell_timer.sv
module sir_cell_timer #(
   parameter int TICKS_PER_BIT = 16,
   parameter int PULSE_POS     = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick16,
   input  logic cell_start,
   output logic fire
);
   localparam int IW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
   localparam logic [IW-1:0] LAST = IW'(TICKS_PER_BIT - 1);
   localparam logic [IW-1:0] POS  = IW'(PULSE_POS);

   logic [IW-1:0] idx_q;
   logic [IW-1:0] idx_nx;

   always_comb begin
      if (cell_start)
         idx_nx = '0;
      else if (idx_q == LAST)
         idx_nx = '0;
      else
         idx_nx = idx_q + IW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= LAST;
      else if (tick16)
         idx_q <= idx_nx;
   end

   assign fire = tick16 && (idx_nx == POS);
endmodule

// File: rtl/sir_pulse_gen.sv
module sir_pulse_gen
   import sir_pkg::*;
#(
   parameter int PULSE_TICKS = 3,
   parameter int LP_TICKS    = 3,
   parameter bit LP_SUPPORT  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic fire,
   input  logic data,
   input  logic lp_sel,
   input  logic tick16,
   input  logic lp_tick,
   output logic lit
);
   localparam int CW = $clog2(max_int(PULSE_TICKS, LP_TICKS) + 1);
   localparam logic [CW-1:0] LIM_TICK = CW'(PULSE_TICKS - 1);
   localparam logic [CW-1:0] LIM_LP   = CW'(LP_TICKS - 1);

   width_src_e    pick;
   width_src_e    src_q;
   logic [CW-1:0] wcnt_q;
   logic [CW-1:0] limit;
   logic          step;

   generate
      if (LP_SUPPORT) begin : g_lp
         assign pick = lp_sel ? WIDTH_LP : WIDTH_TICK;
      end else begin : g_nolp
         assign pick = WIDTH_TICK;
      end
   endgenerate

   assign step  = (src_q == WIDTH_LP) ? lp_tick : tick16;
   assign limit = (src_q == WIDTH_LP) ? LIM_LP : LIM_TICK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lit    <= 1'b0;
         wcnt_q <= '0;
         src_q  <= WIDTH_TICK;
      end else if (!enable) begin
         lit    <= 1'b0;
         wcnt_q <= '0;
      end else if (fire && !data && !lit) begin
         lit    <= 1'b1;
         wcnt_q <= '0;
         src_q  <= pick;
      end else if (lit && step) begin
         if (wcnt_q == limit) begin
            lit    <= 1'b0;
            wcnt_q <= '0;
         end else begin
            wcnt_q <= wcnt_q + CW'(1);
         end
      end
   end
endmodule

// File: rtl/sir_route.sv
module sir_route (
   input  logic active,
   input  logic lit,
   input  logic loop_en,
   input  logic sir_test,
   input  logic tx_nrz,
   input  logic rxd,
   input  logic ir_rx_n,
   output logic txd,
   output logic rxd_path,
   output logic ir_led_n,
   output logic ir_sense
);
   logic test_loop;
   logic line_loop;

   assign test_loop = active && loop_en && sir_test;
   assign line_loop = loop_en && !sir_test;

   assign txd      = active ? 1'b1 : tx_nrz;
   assign ir_led_n = !(active && lit);

   always_comb begin
      if (!active)
         ir_sense = 1'b0;
      else if (test_loop)
         ir_sense = !ir_led_n;
      else
         ir_sense = !ir_rx_n;
   end

   always_comb begin
      if (active)
         rxd_path = 1'b1;
      else if (line_loop)
         rxd_path = txd;
      else
         rxd_path = rxd;
   end
endmodule

// File: rtl/sir_pulse_enc.sv
module sir_pulse_enc #(
   parameter int TICKS_PER_BIT = 16,
   parameter int PULSE_POS     = 7,
   parameter int PULSE_TICKS   = 3,
   parameter int LP_TICKS      = 3,
   parameter bit LP_SUPPORT    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uart_en,
   input  logic sir_en,
   input  logic lp_sel,
   input  logic loop_en,
   input  logic sir_test,
   input  logic tick16,
   input  logic cell_start,
   input  logic lp_tick,
   input  logic tx_nrz,
   input  logic rxd,
   input  logic ir_rx_n,
   output logic txd,
   output logic rxd_path,
   output logic ir_led_n,
   output logic ir_sense
);
   generate
      if (TICKS_PER_BIT < 4) begin : g_bad_cell
         $error("cell must hold at least four ticks");
      end
      if (PULSE_TICKS < 1 || LP_TICKS < 1) begin : g_bad_width
         $error("pulse widths must be at least one tick");
      end
      if (PULSE_POS + PULSE_TICKS >= TICKS_PER_BIT) begin : g_bad_pos
         $error("pulse must end inside its bit cell");
      end
   endgenerate

   logic active;
   logic fire;
   logic lit;

   assign active = uart_en && sir_en;

   sir_cell_timer #(
      .TICKS_PER_BIT (TICKS_PER_BIT),
      .PULSE_POS     (PULSE_POS)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick16     (tick16),
      .cell_start (cell_start),
      .fire       (fire)
   );

   sir_pulse_gen #(
      .PULSE_TICKS (PULSE_TICKS),
      .LP_TICKS    (LP_TICKS),
      .LP_SUPPORT  (LP_SUPPORT)
   ) u_pulse (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (active),
      .fire    (fire),
      .data    (tx_nrz),
      .lp_sel  (lp_sel),
      .tick16  (tick16),
      .lp_tick (lp_tick),
      .lit     (lit)
   );

   sir_route u_route (
      .active   (active),
      .lit      (lit),
      .loop_en  (loop_en),
      .sir_test (sir_test),
      .tx_nrz   (tx_nrz),
      .rxd      (rxd),
      .ir_rx_n  (ir_rx_n),
      .txd      (txd),
      .rxd_path (rxd_path),
      .ir_led_n (ir_led_n),
      .ir_sense (ir_sense)
   );
endmodule

// File: rtl/sir_pulse_enc_chk.sv
module sir_pulse_enc_chk (
   input logic clk,
   input logic rst_n,
   input logic uart_en,
   input logic sir_en,
   input logic loop_en,
   input logic sir_test,
   input logic tick16,
   input logic tx_nrz,
   input logic txd,
   input logic rxd_path,
   input logic ir_led_n,
   input logic ir_sense
);
   p_light_from_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ir_led_n) |-> ($past(tick16) && !$past(tx_nrz)));

   p_dark_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(uart_en && sir_en) |-> (ir_led_n && !ir_sense));

   p_off_after_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(uart_en && sir_en) && !(uart_en && sir_en)) |-> ir_led_n);

   p_marking_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (uart_en && sir_en) |-> (txd && rxd_path));

   p_test_loop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (uart_en && sir_en && loop_en && sir_test) |-> (ir_sense == !ir_led_n));

   p_line_loop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (loop_en && !sir_test && !(uart_en && sir_en)) |-> (rxd_path == txd));

   always_comb begin
      if (!rst_n) begin
         a_reset_dark_r9: assert (ir_led_n);
      end
   end
endmodule

bind sir_pulse_enc sir_pulse_enc_chk u_chk (.*);

// File: tb/tb_sir_pulse_enc.sv
module tb_sir_pulse_enc;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n;
   logic uart_en, sir_en, lp_sel, loop_en, sir_test;
   logic tick16, cell_start, lp_tick, tx_nrz, rxd, ir_rx_n;
   logic txd, rxd_path, ir_led_n, ir_sense;

   int checks = 0;
   int errors = 0;
   int gcyc = 0;
   int div = 4;
   int lpdiv = 5;

   always #(CLK_PERIOD/2) clk = ~clk;

   sir_pulse_enc dut (
      .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .sir_en(sir_en),
      .lp_sel(lp_sel), .loop_en(loop_en), .sir_test(sir_test),
      .tick16(tick16), .cell_start(cell_start), .lp_tick(lp_tick),
      .tx_nrz(tx_nrz), .rxd(rxd), .ir_rx_n(ir_rx_n),
      .txd(txd), .rxd_path(rxd_path), .ir_led_n(ir_led_n), .ir_sense(ir_sense)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One bit cell. b: bit value; flip: raise tx_nrz mid-pulse; en: encoder active; lp: low-power mode
   task automatic run_cell(input string req, input bit b, input bit flip, input bit en, input bit lp);
      int ncyc = 16 * div;
      int light = 0;
      int first = -1;
      int route_bad = 0;
      int g0 = 0;
      int exp_w;
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         if (c >= 1) begin
            if (!ir_led_n) begin
               light++;
               if (first < 0) first = c;
            end
            if (txd !== (en ? 1'b1 : b)) route_bad++;
            if (!en && ir_sense !== 1'b0) route_bad++;
            if (en && !loop_en && ir_sense !== !ir_rx_n) route_bad++;
         end
         if (c == 7 * div) g0 = gcyc;
         tick16     = (c % div == 0);
         cell_start = (c == 0);
         lp_tick    = (gcyc % lpdiv == 0);
         tx_nrz     = (flip && c >= 7 * div + 2) ? 1'b1 : b;
         ir_rx_n    = c[0];
         gcyc++;
      end
      if (!en || b) begin
         exp_w = 0;
      end else if (lp) begin
         int n = 0;
         int g = g0;
         while (n < 3) begin
            g++;
            if (g % lpdiv == 0) n++;
         end
         exp_w = g - g0;
      end else begin
         exp_w = 3 * div;
      end
      check({req, " width"}, light, exp_w);
      if (exp_w > 0) check({req, " start offset"}, first, 7 * div + 1);
      check({req, " routing"}, route_bad, 0);
   endtask

   initial begin
      int wd = 0;
      while (wd < 150000) begin
         @(posedge clk);
         wd++;
      end
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      uart_en = 1'b1; sir_en = 1'b0; lp_sel = 1'b0; loop_en = 1'b0; sir_test = 1'b0;
      tick16 = 1'b0; cell_start = 1'b0; lp_tick = 1'b0;
      tx_nrz = 1'b1; rxd = 1'b0; ir_rx_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 reset dark", ir_led_n, 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 dark after reset", ir_led_n, 1);

      // R5: encoder off, zero bits give no light
      run_cell("R5 sir off zero", 1'b0, 1'b0, 1'b0, 1'b0);
      uart_en = 1'b0; sir_en = 1'b1;
      run_cell("R5 uart off zero", 1'b0, 1'b0, 1'b0, 1'b0);
      uart_en = 1'b1;

      // R1/R2 normal mode, two bit rates
      for (int d = 2; d <= 4; d += 2) begin
         div = d;
         run_cell("R1 normal zero", 1'b0, 1'b0, 1'b1, 1'b0);
         run_cell("R2 normal one", 1'b1, 1'b0, 1'b1, 1'b0);
         run_cell("R1 normal zero again", 1'b0, 1'b0, 1'b1, 1'b0);
         run_cell("R4 normal flip", 1'b0, 1'b1, 1'b1, 1'b0);
      end

      // R3 low-power mode at two bit rates and many reference phases
      lp_sel = 1'b1;
      for (int d = 2; d <= 4; d += 2) begin
         div = d;
         for (int k = 0; k < 5; k++) run_cell("R3 lowpower zero", 1'b0, 1'b0, 1'b1, 1'b1);
         run_cell("R2 lowpower one", 1'b1, 1'b0, 1'b1, 1'b1);
         run_cell("R4 lowpower flip", 1'b0, 1'b1, 1'b1, 1'b1);
      end
      lpdiv = 3;
      for (int k = 0; k < 3; k++) run_cell("R3 lowpower fast ref", 1'b0, 1'b0, 1'b1, 1'b1);
      lp_sel = 1'b0;
      div = 4;

      // R6 routing while active
      @(negedge clk);
      tx_nrz = 1'b0; rxd = 1'b0; ir_rx_n = 1'b0; tick16 = 1'b0; cell_start = 1'b0;
      #1;
      check("R6 txd marking", txd, 1);
      check("R6 rxd_path marking", rxd_path, 1);
      check("R6 sense follows pin", ir_sense, 1);
      ir_rx_n = 1'b1; #1;
      check("R6 sense follows pin high", ir_sense, 0);

      // R7 test loopback: emitter state reaches ir_sense, pin ignored
      loop_en = 1'b1; sir_test = 1'b1;
      ir_rx_n = 1'b0;
      begin
         int bad = 0;
         int lit_seen = 0;
         for (int c = 0; c < 64; c++) begin
            @(negedge clk);
            if (c >= 1) begin
               if (ir_sense !== !ir_led_n) bad++;
               if (!ir_led_n) lit_seen++;
            end
            tick16 = (c % 4 == 0); cell_start = (c == 0); tx_nrz = 1'b0;
            ir_rx_n = c[1];
         end
         check("R7 sense equals emitter", bad, 0);
         check("R7 pulse seen in loop", lit_seen, 12);
      end

      // R8 line loopback with encoder off
      @(negedge clk);
      sir_en = 1'b0; sir_test = 1'b0; tick16 = 1'b0; cell_start = 1'b0;
      rxd = 1'b1; tx_nrz = 1'b0; #1;
      check("R8 line loop low", rxd_path, 0);
      tx_nrz = 1'b1; rxd = 1'b0; #1;
      check("R8 line loop high", rxd_path, 1);
      loop_en = 1'b0; #1;
      check("R8 no loop follows rxd", rxd_path, 0);
      rxd = 1'b1; #1;
      check("R8 no loop follows rxd high", rxd_path, 1);
      ir_rx_n = 1'b0; #1;
      check("R5 sense ignored when off", ir_sense, 0);
      check("R5 txd follows data when off", txd, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule